// File: doc/BRIEF.md
# ALU Status Flag Register

This block keeps the status word of an 8-bit arithmetic unit. The datapath computes a result elsewhere and presents both operands, the result and a code for the kind of operation it performed. When the update strobe is high, the block derives zero, carry, negative, two's-complement overflow, half-carry and sign flags from those values and stores them in a single status register at the next clock edge. Each operation class has its own rule for which flags it touches. The carry and overflow rules differ between addition, subtraction and shifts.

Independently of any arithmetic, a command port can force any single bit of the status word to 1 or to 0. If a command and an update arrive in the same cycle, the command decides the bit it names. The remaining bits still take their computed values. The two top bits carry no arithmetic meaning and act as plain storage that only the command port writes.

Top module: `alu_flag_reg`

## Requirements
- R1: While rst_n is low, and after its release, status reads 0x00 until the first update or command.
- R2: On an update with a valid class (op_class 0..5), Z (bit 1) becomes 1 exactly when every bit of alu_res is 0, for every class.
- R3: On a valid update, N (bit 2) takes bit 7 of alu_res.
- R4: Class add (0) sets C (bit 0) to the carry out of bit 7 of opnd_a+opnd_b. Class subtract (1) sets C to 1 when opnd_b is larger than opnd_a as unsigned numbers (a borrow).
- R5: Class shift-left (2) sets C to bit 7 of opnd_a. Class shift-right (3) sets C to bit 0 of opnd_a. Both set V (bit 3) to N XOR C of the new values.
- R6: For add, V is 1 when both operands share a sign bit and the result's sign differs from it. For subtract, V is 1 when the operand signs differ and the result's sign differs from opnd_a's.
- R7: After any valid update without a command, S (bit 4) equals N XOR V.
- R8: For add, H (bit 5) is the carry out of bit 3. For subtract, H is the borrow into bit 4, meaning the low nibble of opnd_b is larger than that of opnd_a. All other classes leave H unchanged.
- R9: Class logic (4) clears V and keeps C. Class increment/decrement (5) keeps C and computes V as for add, with opnd_b holding the step: 0x01 for increment, 0xFF for decrement.
- R10: With upd_en low, or with op_class 6 or 7, and no command, status holds. Bits 6 and 7 change only through a command.
- R11: When cmd_valid is high, bit cmd_idx of status becomes cmd_set (1 sets, 0 clears) at the next edge.
- R12: A command in the same cycle as an update wins for the bit it names. The other bits take their update values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Load flags from this cycle's operation |
| op_class | input | 3 | 0 add, 1 subtract, 2 shift left, 3 shift right, 4 logic, 5 inc/dec, 6-7 no flag change |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand or inc/dec step |
| alu_res | input | 8 | Result produced by the datapath |
| cmd_valid | input | 1 | Force one status bit this cycle |
| cmd_set | input | 1 | Value written by the command |
| cmd_idx | input | 3 | Bit index targeted by the command |
| status | output | 8 | Status register |

## Verification
The bench builds the block with its defaults: an 8-bit data path, an 8-bit status word and the half-carry logic enabled. With these values the borrow-into-bit-4 and carry-out-of-bit-3 cases are reachable, and so are both spare storage bits at indices 6 and 7. A bench-side model, written from the requirements with plain integer arithmetic, predicts every status value. The directed cases include the 0x80+0x80 wrap, 60+70, the 0x80-1 overflow, decrement to zero, and a command that collides with an update.

// File: rtl/flag_pkg.sv
package flag_pkg;

   // Status bit positions (behavioural: commands address bits by index)
   localparam int unsigned FL_C = 0;
   localparam int unsigned FL_Z = 1;
   localparam int unsigned FL_N = 2;
   localparam int unsigned FL_V = 3;
   localparam int unsigned FL_S = 4;
   localparam int unsigned FL_H = 5;
   localparam int unsigned FL_NUM_ARITH = 6;

   typedef enum logic [2:0] {
      OPC_ADD    = 3'd0,
      OPC_SUB    = 3'd1,
      OPC_SHL    = 3'd2,
      OPC_SHR    = 3'd3,
      OPC_LOGIC  = 3'd4,
      OPC_INCDEC = 3'd5,
      OPC_RSV6   = 3'd6,
      OPC_RSV7   = 3'd7
   } op_class_e;

   typedef struct packed {
      logic any_we;
      logic c_we;
      logic h_we;
      logic c;
      logic z;
      logic n;
      logic v;
      logic h;
   } flag_upd_t;

endpackage

// File: rtl/sr_flag_calc.sv
module sr_flag_calc
   import flag_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int HALF_EN = 1
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] r_i,
   output flag_upd_t         upd_o
);
   localparam int MSB = DATA_W - 1;
   localparam int HB  = DATA_W / 2 - 1;

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("sr_flag_calc: DATA_W must be even and at least 4");
   end
   if (HALF_EN != 0 && HALF_EN != 1) begin : g_bad_half
      $error("sr_flag_calc: HALF_EN must be 0 or 1");
   end

   op_class_e op;
   logic a7, b7, r7, a3, b3, r3;
   logic add_c, add_v, add_h, sub_c, sub_v, sub_h;
   logic half_val, half_we;
   logic unused_bits;

   assign op = op_class_e'(op_i);
   assign a7 = a_i[MSB];
   assign b7 = b_i[MSB];
   assign r7 = r_i[MSB];
   assign a3 = a_i[HB];
   assign b3 = b_i[HB];
   assign r3 = r_i[HB];
   assign unused_bits = ^{a_i, b_i};

   // carry / overflow rules from sign and nibble bits
   assign add_c = (a7 & b7) | (b7 & ~r7) | (~r7 & a7);
   assign add_v = (a7 & b7 & ~r7) | (~a7 & ~b7 & r7);
   assign add_h = (a3 & b3) | (b3 & ~r3) | (~r3 & a3);
   assign sub_c = (~a7 & b7) | (b7 & r7) | (r7 & ~a7);
   assign sub_v = (a7 & ~b7 & ~r7) | (~a7 & b7 & r7);
   assign sub_h = (~a3 & b3) | (b3 & r3) | (r3 & ~a3);

   if (HALF_EN == 1) begin : g_half
      assign half_val = (op == OPC_SUB) ? sub_h : add_h;
      assign half_we  = (op == OPC_ADD) || (op == OPC_SUB);
   end else begin : g_no_half
      assign half_val = 1'b0;
      assign half_we  = 1'b0;
   end

   always_comb begin
      upd_o        = '0;
      upd_o.z      = (r_i == '0);
      upd_o.n      = r7;
      upd_o.h      = half_val;
      upd_o.h_we   = half_we;
      upd_o.any_we = 1'b1;
      unique case (op)
         OPC_ADD: begin
            upd_o.c    = add_c;
            upd_o.c_we = 1'b1;
            upd_o.v    = add_v;
         end
         OPC_SUB: begin
            upd_o.c    = sub_c;
            upd_o.c_we = 1'b1;
            upd_o.v    = sub_v;
         end
         OPC_SHL: begin
            upd_o.c    = a7;
            upd_o.c_we = 1'b1;
            upd_o.v    = r7 ^ a7;
         end
         OPC_SHR: begin
            upd_o.c    = a_i[0];
            upd_o.c_we = 1'b1;
            upd_o.v    = r7 ^ a_i[0];
         end
         OPC_LOGIC: begin
            upd_o.v    = 1'b0;
         end
         OPC_INCDEC: begin
            upd_o.v    = add_v;
         end
         default: begin
            upd_o.any_we = 1'b0;
            upd_o.h_we   = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/sr_cmd_decode.sv
module sr_cmd_decode #(
   parameter int SR_W  = 8,
   parameter int IDX_W = $clog2(SR_W)
) (
   input  logic             valid_i,
   input  logic             set_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [SR_W-1:0]  set_mask_o,
   output logic [SR_W-1:0]  clr_mask_o
);
   if (IDX_W < 1 || (1 << IDX_W) < SR_W) begin : g_bad_idx
      $error("sr_cmd_decode: IDX_W too narrow for SR_W");
   end

   for (genvar i = 0; i < SR_W; i++) begin : g_bit
      logic hit;
      assign hit           = valid_i && (idx_i == IDX_W'(i));
      assign set_mask_o[i] = hit & set_i;
      assign clr_mask_o[i] = hit & ~set_i;
   end

   // at most one bit is forced per cycle
   always_comb begin
      assert ($onehot0(set_mask_o | clr_mask_o))
         else $error("a_r11_single_bit: command touched more than one bit");
   end

endmodule

// File: rtl/sr_flag_store.sv
module sr_flag_store
   import flag_pkg::*;
#(
   parameter int SR_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_en_i,
   input  flag_upd_t       upd_i,
   input  logic [SR_W-1:0] set_mask_i,
   input  logic [SR_W-1:0] clr_mask_i,
   output logic [SR_W-1:0] sr_o
);
   if (SR_W < FL_NUM_ARITH) begin : g_bad_sr
      $error("sr_flag_store: SR_W must hold all arithmetic flags");
   end

   logic [SR_W-1:0] sr_q, merged, sr_d;
   logic            load;

   assign load = upd_en_i && upd_i.any_we;

   always_comb begin
      merged = sr_q;
      if (load) begin
         merged[FL_Z] = upd_i.z;
         merged[FL_N] = upd_i.n;
         merged[FL_V] = upd_i.v;
         merged[FL_S] = upd_i.n ^ upd_i.v;
         if (upd_i.c_we) merged[FL_C] = upd_i.c;
         if (upd_i.h_we) merged[FL_H] = upd_i.h;
      end
      // commands win for the bit they name
      sr_d = (merged & ~clr_mask_i) | set_mask_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
   end

   assign sr_o = sr_q;

   // R12: forced bit beats the computed value
   a_r12_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (set_mask_i != '0)) |=> ((sr_q & $past(set_mask_i)) == $past(set_mask_i)));

   // R10: no load, no command -> hold
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && set_mask_i == '0 && clr_mask_i == '0) |=> $stable(sr_q));

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import flag_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SR_W    = 8,
   parameter int HALF_EN = 1,
   localparam int IDX_W  = $clog2(SR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [2:0]        op_class,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              cmd_valid,
   input  logic              cmd_set,
   input  logic [IDX_W-1:0]  cmd_idx,
   output logic [SR_W-1:0]   status
);
   flag_upd_t       upd;
   logic [SR_W-1:0] set_mask, clr_mask;
   logic            live_q;
   logic            op_ok;

   sr_flag_calc #(.DATA_W(DATA_W), .HALF_EN(HALF_EN)) u_calc (
      .op_i  (op_class),
      .a_i   (opnd_a),
      .b_i   (opnd_b),
      .r_i   (alu_res),
      .upd_o (upd)
   );

   sr_cmd_decode #(.SR_W(SR_W), .IDX_W(IDX_W)) u_cmd (
      .valid_i    (cmd_valid),
      .set_i      (cmd_set),
      .idx_i      (cmd_idx),
      .set_mask_o (set_mask),
      .clr_mask_o (clr_mask)
   );

   sr_flag_store #(.SR_W(SR_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_en_i   (upd_en),
      .upd_i      (upd),
      .set_mask_i (set_mask),
      .clr_mask_i (clr_mask),
      .sr_o       (status)
   );

   // ---------------- checks ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   assign op_ok = (op_class <= 3'd5);

   a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && upd_en && op_ok && !cmd_valid)
         |=> (status[FL_Z] == ($past(alu_res) == '0)));

   a_r3_negative: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && upd_en && op_ok && !cmd_valid)
         |=> (status[FL_N] == $past(alu_res[DATA_W-1])));

   a_r7_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && upd_en && op_ok && !cmd_valid)
         |=> (status[FL_S] == (status[FL_N] ^ status[FL_V])));

   a_r9_logic: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && upd_en && op_class == 3'd4 && !cmd_valid)
         |=> (!status[FL_V] && status[FL_C] == $past(status[FL_C])));

   a_r10_spare: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !cmd_valid) |=> $stable(status[SR_W-1:FL_NUM_ARITH]));

   a_r11_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && cmd_valid) |=> (status[$past(cmd_idx)] == $past(cmd_set)));

endmodule

// File: tb/test_alu_flag_reg.sv
module test_alu_flag_reg;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       upd_en;
   logic [2:0] op_class;
   logic [7:0] opnd_a, opnd_b, alu_res;
   logic       cmd_valid, cmd_set;
   logic [2:0] cmd_idx;
   logic [7:0] status;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] exp_sr;

   always #5 clk = ~clk;

   alu_flag_reg i_alu_flag_reg (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res),
      .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_idx(cmd_idx),
      .status(status)
   );

   // model written from the requirements with integer arithmetic
   function automatic logic [7:0] model(input logic [7:0] p, input logic u,
      input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
      input logic [7:0] r, input logic cv, input logic cs, input logic [2:0] ci);
      logic [7:0] nx;
      logic c, v, h;
      int sum;
      nx = p;
      if (u && op <= 3'd5) begin
         c = p[0]; v = 1'b0; h = p[5];
         case (op)
            3'd0: begin
               sum = int'(a) + int'(b);
               c = (sum > 255);
               h = ((int'(a[3:0]) + int'(b[3:0])) > 15);
               v = (a[7] == b[7]) && (r[7] != a[7]);
            end
            3'd1: begin
               c = (b > a);
               h = (b[3:0] > a[3:0]);
               v = (a[7] != b[7]) && (r[7] != a[7]);
            end
            3'd2: begin c = a[7]; v = r[7] ^ c; end
            3'd3: begin c = a[0]; v = r[7] ^ c; end
            3'd4: v = 1'b0;
            default: v = (a[7] == b[7]) && (r[7] != a[7]);
         endcase
         nx[0] = c; nx[1] = (r == 8'h00); nx[2] = r[7];
         nx[3] = v; nx[4] = r[7] ^ v;   nx[5] = h;
      end
      if (cv) nx[ci] = cs;
      return nx;
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: status=0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   // drive at negedge, one rising edge, check at next negedge
   task automatic step(input string req, input logic u, input logic [2:0] op,
      input logic [7:0] a, input logic [7:0] b, input logic [7:0] r,
      input logic cv, input logic cs, input logic [2:0] ci);
      upd_en = u; op_class = op; opnd_a = a; opnd_b = b; alu_res = r;
      cmd_valid = cv; cmd_set = cs; cmd_idx = ci;
      exp_sr = model(exp_sr, u, op, a, b, r, cv, cs, ci);
      @(negedge clk);
      check(req, status, exp_sr);
      upd_en = 1'b0; cmd_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R1", status, 8'h00);
      exp_sr = 8'h00;
   endtask

   task automatic t_add;
      step("R4 add 0x80+0x80", 1, 3'd0, 8'h80, 8'h80, 8'h00, 0, 0, 0);
      check("R4/R2/R6 literal", status, 8'h1B);
      step("R6 add 60+70", 1, 3'd0, 8'h3C, 8'h46, 8'h82, 0, 0, 0);
      check("R6/R8 literal", status, 8'h2C);
      step("R8 add half carry", 1, 3'd0, 8'h0F, 8'h01, 8'h10, 0, 0, 0);
      check("R8 literal", status, 8'h20);
      step("R3 add negative", 1, 3'd0, 8'hF0, 8'h01, 8'hF1, 0, 0, 0);
   endtask

   task automatic t_sub;
      step("R4 sub borrow", 1, 3'd1, 8'h10, 8'h20, 8'hF0, 0, 0, 0);
      check("R4 sub literal", status, 8'h15);
      step("R6 sub overflow", 1, 3'd1, 8'h80, 8'h01, 8'h7F, 0, 0, 0);
      check("R6/R8 sub literal", status, 8'h38);
      step("R2 sub equal", 1, 3'd1, 8'h55, 8'h55, 8'h00, 0, 0, 0);
   endtask

   task automatic t_shift;
      step("R5 shl out 1", 1, 3'd2, 8'h81, 8'h00, 8'h02, 0, 0, 0);
      step("R5 shr out 1", 1, 3'd3, 8'h01, 8'h00, 8'h00, 0, 0, 0);
      step("R5 shl out 0", 1, 3'd2, 8'h40, 8'h00, 8'h80, 0, 0, 0);
   endtask

   task automatic t_logic_incdec;
      step("R4 set C first", 1, 3'd0, 8'hFF, 8'h01, 8'h00, 0, 0, 0);
      step("R9 logic keeps C", 1, 3'd4, 8'hF0, 8'h0F, 8'h00, 0, 0, 0);
      step("R9 inc overflow", 1, 3'd5, 8'h7F, 8'h01, 8'h80, 0, 0, 0);
      step("R9 dec to zero", 1, 3'd5, 8'h01, 8'hFF, 8'h00, 0, 0, 0);
      step("R9 dec 0x80", 1, 3'd5, 8'h80, 8'hFF, 8'h7F, 0, 0, 0);
   endtask

   task automatic t_hold;
      step("R10 idle", 0, 3'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0);
      step("R10 upd_en low", 0, 3'd1, 8'h00, 8'h01, 8'hFF, 0, 0, 0);
      step("R10 reserved op", 1, 3'd6, 8'h00, 8'h00, 8'h00, 0, 0, 0);
   endtask

   task automatic t_cmd;
      step("R11 set bit7", 0, 3'd0, 0, 0, 0, 1, 1, 3'd7);
      step("R11 set bit6", 0, 3'd0, 0, 0, 0, 1, 1, 3'd6);
      step("R10 spare bits kept", 1, 3'd0, 8'h01, 8'h01, 8'h02, 0, 0, 0);
      step("R11 set H", 0, 3'd0, 0, 0, 0, 1, 1, 3'd5);
      step("R11 clear H", 0, 3'd0, 0, 0, 0, 1, 0, 3'd5);
      step("R11 clear bit7", 0, 3'd0, 0, 0, 0, 1, 0, 3'd7);
   endtask

   task automatic t_priority;
      step("R12 clear Z over zero", 1, 3'd0, 8'h80, 8'h80, 8'h00, 1, 0, 3'd1);
      check("R12 literal", status, 8'h59);
      step("R12 set N over positive", 1, 3'd1, 8'h05, 8'h01, 8'h04, 1, 1, 3'd2);
   endtask

   initial begin
      rst_n = 1'b0; upd_en = 1'b0; op_class = 3'd0;
      opnd_a = 8'h00; opnd_b = 8'h00; alu_res = 8'h00;
      cmd_valid = 1'b0; cmd_set = 1'b0; cmd_idx = 3'd0;
      exp_sr = 8'h00;
      repeat (3) @(negedge clk);
      check("R1 in reset", status, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_shift();
      t_logic_incdec();
      t_hold();
      t_cmd();
      t_priority();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule